// File: doc/BRIEF.md
# Serial Audio Link Reset and Power Sequencer

This block is the global control section of a serial audio link controller with a 48 kHz frame, one SYNC line, one serial data output and a bit clock that the codec drives. A host programs one control register and one status register through a simple synchronous register port. From those settings the block drives the link reset line, forwards or silences the SYNC and serial data produced by the frame formatter, and gates the link input buffers. It also sequences a warm reset by holding SYNC high while the bit clock is stopped.

A monitor in the system clock domain watches the incoming bit clock through a two-flop synchronizer and an edge timeout. It reports whether the clock is running. That flag decides whether a warm-reset request is taken or dropped, and when an accepted request completes. The frame decoder supplies one-cycle pulses for a codec GPI change and for resume events from the primary and secondary codecs. These pulses latch sticky status bits. The single interrupt output combines those bits with their enables.

Control register (address 0) fields: bit 0 cold-release, bit 1 warm request, bit 2 link off, bit 3 GPI interrupt enable, bit 4 primary resume enable, bit 5 secondary resume enable. Status register (address 1) fields: bit 0 GPI change, bit 1 primary resume, bit 2 secondary resume.

Top module: `link_power_ctrl`

## Requirements
- R1: After reset, linkResetN is 0, the control register (address 0) reads 0, the status register (address 1) reads 0, and linkSync, linkSdataOut and irq are 0.
- R2: Control bit 0 is an active-low cold-reset control. Writing it as 1 drives linkResetN high from the clock edge of the write. Writing it as 0 drives linkResetN low again.
- R3: A write with control bit 1 set is dropped while bitClkRunning is 1. Bit 1 still reads 0 afterwards, and linkSync does not rise.
- R4: A write with control bit 1 set while bitClkRunning is 0 is accepted. linkSync is high for exactly WARM_CYCLES system clocks starting at the write's clock edge, and bit 1 reads 1.
- R5: After the SYNC pulse, control bit 1 stays 1 as long as the bit clock stays stopped. It clears by itself once bitClkRunning returns to 1.
- R6: With control bit 2 (link off) set, linkSync, linkSdataOut and linkInputEn are 0 whatever frameSync and frameSdata are, and linkResetN stays 1.
- R7: With bit 0 set and bit 2 clear, linkSync follows frameSync, linkSdataOut follows frameSdata and linkInputEn is 1. Clearing bit 2 restores this forwarding.
- R8: A gpiChangePulse sets status bit 0 whatever the enable is. irq is 1 only when control bit 3 is also set.
- R9: priResumePulse sets status bit 1 and secResumePulse sets status bit 2. Each raises irq only through its own enable, control bit 4 or bit 5 respectively.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event pulse in the same cycle as a clearing write leaves the bit set.
- R11: bitClkRunning rises within a few system clocks of bit-clock edges appearing. It falls after TIMEOUT_CYCLES system clocks with no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects control, 1 selects status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| bitClkIn | input | 1 | Bit clock from the codec (asynchronous) |
| frameSync | input | 1 | SYNC from the frame formatter |
| frameSdata | input | 1 | Serial data from the frame formatter |
| gpiChangePulse | input | 1 | One-cycle codec GPI change event |
| priResumePulse | input | 1 | One-cycle primary codec resume event |
| secResumePulse | input | 1 | One-cycle secondary codec resume event |
| linkResetN | output | 1 | Link reset line, active low |
| linkSync | output | 1 | SYNC line to the link |
| linkSdataOut | output | 1 | Serial data line to the link |
| linkInputEn | output | 1 | Enable for the link input buffers |
| bitClkRunning | output | 1 | Bit clock detected as active |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational. Control-bit effects, status-bit updates and the start of the warm SYNC pulse all appear one system clock edge after the stimulus, and irq follows its status bit in the same cycle. The bench drives inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. The pulse width is counted cycle by cycle against WARM_CYCLES. Bit-clock detection passes through a synchronizer and a timeout, so those checks wait a bounded margin beyond the 3-cycle detection path and beyond TIMEOUT_CYCLES rather than sampling a single cycle.

// File: rtl/link_power_pkg.sv
package link_power_pkg;

  // control register field positions
  localparam int COLD_BIT   = 0;
  localparam int WARM_BIT   = 1;
  localparam int OFF_BIT    = 2;
  localparam int GPI_IE_BIT = 3;
  localparam int PRI_IE_BIT = 4;
  localparam int SEC_IE_BIT = 5;

  // status register field positions
  localparam int ST_GPI = 0;
  localparam int ST_PRI = 1;
  localparam int ST_SEC = 2;
  localparam int ST_W   = 3;

  typedef enum logic [1:0] {
    WARM_IDLE  = 2'd0,
    WARM_PULSE = 2'd1,
    WARM_WAIT  = 2'd2
  } warmState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic warmSet;
    logic warmClr;
    logic warmSyncOn;
  } ctrlStrobe_t;

endpackage

// File: rtl/link_bitclk_monitor.sv
module link_bitclk_monitor #(
  parameter int TIMEOUT_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitClkIn,
  output logic clkRunning
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic syncA, syncB, prevLevel;
  logic [CNT_W-1:0] idleCnt;
  logic edgeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      prevLevel <= 1'b0;
    end else begin
      syncA     <= bitClkIn;
      syncB     <= syncA;
      prevLevel <= syncB;
    end
  end

  assign edgeSeen = syncB ^ prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt    <= '0;
      clkRunning <= 1'b0;
    end else if (edgeSeen) begin
      idleCnt    <= '0;
      clkRunning <= 1'b1;
    end else if (idleCnt == CNT_LAST) begin
      clkRunning <= 1'b0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // running drops only when the idle window is fully used
  assert_timeout_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRunning) |-> $past(idleCnt) == CNT_LAST);

  // an edge always marks the clock as running on the next cycle
  assert_edge_marks_running_R11: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> clkRunning);

endmodule

// File: rtl/link_power_seq.sv
module link_power_seq
  import link_power_pkg::*;
#(
  parameter int WARM_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic        warmReqBit,
  input  logic        clkRunning,
  output ctrlStrobe_t strobe
);
  localparam int PW_W = (WARM_CYCLES > 2) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(WARM_CYCLES - 1);

  warmState_t state, stateNext;
  logic [PW_W-1:0] pulseCnt;
  logic wrCtrl, wrStat, warmSet, warmClr;

  assign wrCtrl  = regWrEn && (regAddr == 1'b0);
  assign wrStat  = regWrEn && (regAddr == 1'b1);
  assign warmSet = wrCtrl && warmReqBit && !clkRunning && (state == WARM_IDLE);
  assign warmClr = (state == WARM_WAIT) && clkRunning;

  always_comb begin
    stateNext = state;
    case (state)
      WARM_IDLE:  if (warmSet) stateNext = WARM_PULSE;
      WARM_PULSE: if (pulseCnt == PW_LAST) stateNext = WARM_WAIT;
      WARM_WAIT:  if (clkRunning) stateNext = WARM_IDLE;
      default:    stateNext = WARM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= WARM_IDLE;
      pulseCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == WARM_PULSE) pulseCnt <= pulseCnt + 1'b1;
      else                     pulseCnt <= '0;
    end
  end

  always_comb begin
    strobe.wrCtrl     = wrCtrl;
    strobe.wrStat     = wrStat;
    strobe.warmSet    = warmSet;
    strobe.warmClr    = warmClr;
    strobe.warmSyncOn = (state == WARM_PULSE);
  end

  // a request made while the clock runs leaves the sequencer idle
  assert_warm_refused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && warmReqBit && clkRunning && state == WARM_IDLE) |=> state == WARM_IDLE);

  // the SYNC pulse never outlasts its programmed length
  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == WARM_PULSE) |-> pulseCnt <= PW_LAST);

  // the wait phase ends only on a detected clock
  assert_wait_needs_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == WARM_WAIT && !clkRunning) |=> state == WARM_WAIT);

endmodule

// File: rtl/link_power_dp.sv
module link_power_dp
  import link_power_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             frameSync,
  input  logic             frameSdata,
  input  logic             gpiChangePulse,
  input  logic             priResumePulse,
  input  logic             secResumePulse,
  output logic             linkResetN,
  output logic             linkSync,
  output logic             linkSdataOut,
  output logic             linkInputEn,
  output logic             irq,
  output logic [REG_W-1:0] regRdData
);
  logic coldRelease, warmBit, linkOff, gpiIe, priIe, secIe;
  logic [ST_W-1:0] status, events, clearMask, enables;
  logic linkActive;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:SEC_IE_BIT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coldRelease <= 1'b0;
      linkOff     <= 1'b0;
      gpiIe       <= 1'b0;
      priIe       <= 1'b0;
      secIe       <= 1'b0;
    end else if (strobe.wrCtrl) begin
      coldRelease <= regWrData[COLD_BIT];
      linkOff     <= regWrData[OFF_BIT];
      gpiIe       <= regWrData[GPI_IE_BIT];
      priIe       <= regWrData[PRI_IE_BIT];
      secIe       <= regWrData[SEC_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmBit <= 1'b0;
    else if (strobe.warmSet) warmBit <= 1'b1;
    else if (strobe.warmClr) warmBit <= 1'b0;
  end

  always_comb begin
    events            = '0;
    events[ST_GPI]    = gpiChangePulse;
    events[ST_PRI]    = priResumePulse;
    events[ST_SEC]    = secResumePulse;
    clearMask         = strobe.wrStat ? regWrData[ST_W-1:0] : '0;
    enables           = '0;
    enables[ST_GPI]   = gpiIe;
    enables[ST_PRI]   = priIe;
    enables[ST_SEC]   = secIe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clearMask) | events;
  end

  assign linkActive   = coldRelease && !linkOff;
  assign linkResetN   = coldRelease;
  assign linkSync     = strobe.warmSyncOn || (linkActive && frameSync);
  assign linkSdataOut = linkActive && frameSdata;
  assign linkInputEn  = linkActive;
  assign irq          = |(status & enables);

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) begin
      regRdData[COLD_BIT]   = coldRelease;
      regRdData[WARM_BIT]   = warmBit;
      regRdData[OFF_BIT]    = linkOff;
      regRdData[GPI_IE_BIT] = gpiIe;
      regRdData[PRI_IE_BIT] = priIe;
      regRdData[SEC_IE_BIT] = secIe;
    end else begin
      regRdData[ST_W-1:0] = status;
    end
  end

  // leaving cold reset needs a host write
  assert_cold_by_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkResetN) |-> $past(strobe.wrCtrl));

  // a GPI event is always recorded
  assert_gpi_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    gpiChangePulse |=> status[ST_GPI]);

  // the warm bit falls only on completion from the sequencer
  assert_warm_self_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(warmBit) |-> $past(strobe.warmClr));

  // an event beats a simultaneous clearing write
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (secResumePulse && strobe.wrStat) |=> status[ST_SEC]);

endmodule

// File: rtl/link_power_ctrl.sv
module link_power_ctrl
  import link_power_pkg::*;
#(
  parameter int REG_W          = 8,
  parameter int WARM_CYCLES    = 50,
  parameter int TIMEOUT_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             bitClkIn,
  input  logic             frameSync,
  input  logic             frameSdata,
  input  logic             gpiChangePulse,
  input  logic             priResumePulse,
  input  logic             secResumePulse,
  output logic             linkResetN,
  output logic             linkSync,
  output logic             linkSdataOut,
  output logic             linkInputEn,
  output logic             bitClkRunning,
  output logic             irq
);
  ctrlStrobe_t strobe;

  link_bitclk_monitor #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_monitor (
    .clk        (clk),
    .rstN       (rstN),
    .bitClkIn   (bitClkIn),
    .clkRunning (bitClkRunning)
  );

  link_power_seq #(.WARM_CYCLES(WARM_CYCLES)) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .warmReqBit (regWrData[WARM_BIT]),
    .clkRunning (bitClkRunning),
    .strobe     (strobe)
  );

  link_power_dp #(.REG_W(REG_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .regAddr        (regAddr),
    .regWrData      (regWrData),
    .frameSync      (frameSync),
    .frameSdata     (frameSdata),
    .gpiChangePulse (gpiChangePulse),
    .priResumePulse (priResumePulse),
    .secResumePulse (secResumePulse),
    .linkResetN     (linkResetN),
    .linkSync       (linkSync),
    .linkSdataOut   (linkSdataOut),
    .linkInputEn    (linkInputEn),
    .irq            (irq),
    .regRdData      (regRdData)
  );

endmodule

// File: tb/link_power_ctrl_bench.sv
module link_power_ctrl_bench;
  localparam int WARM    = 50;
  localparam int TIMEOUT = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic bitClkIn = 1'b0;
  logic bitClkOn = 1'b0;
  logic frameSync = 1'b0, frameSdata = 1'b0;
  logic gpiChangePulse = 1'b0, priResumePulse = 1'b0, secResumePulse = 1'b0;
  logic linkResetN, linkSync, linkSdataOut, linkInputEn, bitClkRunning, irq;

  int checks = 0;
  int fails  = 0;

  link_power_ctrl u_link_power_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bitClkIn(bitClkIn),
    .frameSync(frameSync), .frameSdata(frameSdata),
    .gpiChangePulse(gpiChangePulse), .priResumePulse(priResumePulse),
    .secResumePulse(secResumePulse), .linkResetN(linkResetN),
    .linkSync(linkSync), .linkSdataOut(linkSdataOut), .linkInputEn(linkInputEn),
    .bitClkRunning(bitClkRunning), .irq(irq)
  );

  always #10 clk = ~clk;

  always begin
    if (bitClkOn) #40 bitClkIn = ~bitClkIn;
    else          #20;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic addr, output logic [7:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    readReg(1'b0, v);
    check("R1 ctrl", int'(v), 0);
    readReg(1'b1, v);
    check("R1 status", int'(v), 0);
    check("R1 resetN", int'(linkResetN), 0);
    check("R1 sync", int'(linkSync), 0);
    check("R1 sdata", int'(linkSdataOut), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_cold();
    logic [7:0] v;
    writeReg(1'b0, 8'h01);
    check("R2 release", int'(linkResetN), 1);
    readReg(1'b0, v);
    check("R2 readback", int'(v), 1);
    writeReg(1'b0, 8'h00);
    check("R2 assert", int'(linkResetN), 0);
    writeReg(1'b0, 8'h01);
    check("R2 release again", int'(linkResetN), 1);
  endtask

  task automatic t_bitclk();
    bitClkOn = 1'b1;
    idle(10);
    check("R11 running", int'(bitClkRunning), 1);
    bitClkOn = 1'b0;
    idle(TIMEOUT + 10);
    check("R11 stopped", int'(bitClkRunning), 0);
  endtask

  task automatic t_warm_refused();
    logic [7:0] v;
    int highSeen = 0;
    bitClkOn = 1'b1;
    idle(10);
    writeReg(1'b0, 8'h03);
    readReg(1'b0, v);
    check("R3 warm bit", int'(v[1]), 0);
    for (int i = 0; i < 6; i++) begin
      if (linkSync) highSeen++;
      @(negedge clk);
    end
    check("R3 sync stays low", highSeen, 0);
    bitClkOn = 1'b0;
    idle(TIMEOUT + 10);
  endtask

  task automatic t_warm();
    logic [7:0] v;
    int width = 0;
    writeReg(1'b0, 8'h03);
    readReg(1'b0, v);
    check("R4 warm bit set", int'(v[1]), 1);
    while (linkSync && width < 4 * WARM) begin
      width++;
      @(negedge clk);
    end
    check("R4 pulse width", width, WARM);
    idle(20);
    readReg(1'b0, v);
    check("R5 held while stopped", int'(v[1]), 1);
    bitClkOn = 1'b1;
    idle(10);
    readReg(1'b0, v);
    check("R5 self clear", int'(v[1]), 0);
    bitClkOn = 1'b0;
    idle(TIMEOUT + 10);
  endtask

  task automatic t_linkoff();
    frameSync = 1'b1; frameSdata = 1'b1;
    @(negedge clk);
    check("R7 sync forwards", int'(linkSync), 1);
    check("R7 sdata forwards", int'(linkSdataOut), 1);
    check("R7 input enable", int'(linkInputEn), 1);
    writeReg(1'b0, 8'h05);
    check("R6 sync low", int'(linkSync), 0);
    check("R6 sdata low", int'(linkSdataOut), 0);
    check("R6 input off", int'(linkInputEn), 0);
    check("R6 reset held high", int'(linkResetN), 1);
    writeReg(1'b0, 8'h01);
    check("R7 restored sync", int'(linkSync), 1);
    check("R7 restored input", int'(linkInputEn), 1);
    frameSync = 1'b0; frameSdata = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    gpiChangePulse = (which == 0);
    priResumePulse = (which == 1);
    secResumePulse = (which == 2);
    @(negedge clk);
    gpiChangePulse = 1'b0; priResumePulse = 1'b0; secResumePulse = 1'b0;
  endtask

  task automatic t_gpi();
    logic [7:0] v;
    pulse(0);
    readReg(1'b1, v);
    check("R8 status set unmasked", int'(v), 1);
    check("R8 irq masked", int'(irq), 0);
    writeReg(1'b0, 8'h09);
    check("R8 irq enabled", int'(irq), 1);
    writeReg(1'b1, 8'h01);
    readReg(1'b1, v);
    check("R10 w1c cleared", int'(v), 0);
    check("R8 irq after clear", int'(irq), 0);
  endtask

  task automatic t_resume();
    logic [7:0] v;
    writeReg(1'b0, 8'h11);
    pulse(2);
    readReg(1'b1, v);
    check("R9 secondary status", int'(v), 4);
    check("R9 secondary masked", int'(irq), 0);
    pulse(1);
    readReg(1'b1, v);
    check("R9 primary status", int'(v), 6);
    check("R9 primary irq", int'(irq), 1);
    writeReg(1'b0, 8'h21);
    check("R9 secondary enable irq", int'(irq), 1);
    writeReg(1'b1, 8'h07);
    check("R9 cleared irq", int'(irq), 0);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    pulse(0); pulse(1); pulse(2);
    writeReg(1'b1, 8'h02);
    readReg(1'b1, v);
    check("R10 zero bits untouched", int'(v), 5);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'h05; gpiChangePulse = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; gpiChangePulse = 1'b0;
    readReg(1'b1, v);
    check("R10 set beats clear", int'(v), 1);
    writeReg(1'b1, 8'h07);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_cold();
    t_bitclk();
    t_warm_refused();
    t_warm();
    t_linkoff();
    t_gpi();
    t_resume();
    t_w1c();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule